// File: doc/BRIEF.md
# Small-Page NAND Command and Address Front End

This block sits on the device side of a flash part that uses one shared 8-bit bus for commands, addresses and data. Bus cycles are taken on each rising edge of the active-low write strobe while the active-low chip select is asserted. The strobe is oversampled by the local clock. Two qualifiers mark each cycle: the command latch marks a command byte, the address latch marks an address byte, and with both low the byte is data. The front end decodes command bytes and gathers the address bytes that follow. It keeps the register area pointer, which selects the lower half, the upper half or the 16-byte spare tail of a 528-byte page. It then raises one-cycle operation strobes that carry a complete column and row.

A page read and a page program each take three address bytes: the column byte, then the low row byte, then the high row byte. The column byte is offset by the current area. A block erase is opened by one command, takes two row bytes, and runs only when a confirming command arrives. The erase strobe carries the block number, which is the row with its five page bits dropped. During a program, each data byte produces a write strobe toward the page register. The column advances after each byte and wraps inside the selected area. The array, the page register storage and busy timing are outside this block.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus cycle is taken only on a low-to-high transition of `we_n` while `ce_n` is low. With `cle` high and `ale` low it is a command. With `ale` high and `cle` low it is an address. With both low it is data. Any resulting strobe appears one clock after the clock edge that sees `we_n` high following a low sample.
- R2: Command 00h sets `area` to 0, 01h sets it to 1 and 50h sets it to 2, and each opens a read. After three address cycles, `rd_go` pulses. `op_row` is built from the second byte as bits 7:0 and bits 6:0 of the third byte as bits 14:8.
- R3: The internal column is formed from the column byte b. In area 0 it is b, in area 1 it is 256+b, and in area 2 it is 512 plus the low 4 bits of b.
- R4: When `rd_go` or `prog_go` is issued from area 1, `area` returns to 0. Area 0 and area 2 are kept.
- R5: Command 50h is ignored while `se_n` is high, and `area` is left unchanged.
- R6: Command 80h takes three address cycles. Each later data cycle then pulses `pg_we` with `pg_data` and `pg_col`. The column starts at the loaded column and increments, wrapping from 255 to 0, from 511 to 256, and from 527 to 512. Command 10h then pulses `prog_go` with the starting column and the row.
- R7: Command 10h is ignored when no program is in its data phase.
- R8: Command 60h followed by two row address cycles and then D0h pulses `erase_go` with `erase_blk` = row bits 14:5. D0h in any other situation is ignored.
- R9: Address cycles beyond the count that the open operation expects are ignored, and so are data cycles outside a program data phase.
- R10: Command FFh pulses `reset_go`, abandons any partial sequence and sets `area` to 0.
- R11: Command 90h pulses `id_go`. Command 70h pulses `status_go` and leaves an open sequence intact. Any other byte value in a command cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, bus byte taken on its rising edge |
| cle | input | 1 | Marks a command cycle |
| ale | input | 1 | Marks an address cycle |
| se_n | input | 1 | Spare-area enable, low allows 50h |
| io | input | 8 | Shared command, address and data bus |
| rd_go | output | 1 | Page read strobe |
| prog_go | output | 1 | Page program strobe |
| erase_go | output | 1 | Block erase strobe |
| id_go | output | 1 | Identifier read strobe |
| status_go | output | 1 | Status read strobe |
| reset_go | output | 1 | Reset strobe |
| op_col | output | 10 | Column for read or program |
| op_row | output | 15 | Row for read or program |
| erase_blk | output | 10 | Block number for erase |
| pg_we | output | 1 | Page register write strobe |
| pg_col | output | 10 | Page register column for the write |
| pg_data | output | 8 | Page register byte |
| area | output | 2 | Area pointer: 0 lower half, 1 upper half, 2 spare |

## Verification
The hardest states to reach from the ports are the points where several pieces of history meet. One is a data burst that runs past the end of the upper half or the spare tail, after a program opened while the pointer still pointed at a non-default area. The others are stray commands and extra address bytes that arrive inside an open sequence. The stimulus therefore chains commands: it selects an area, opens a program with a column near the area's end, and injects a status command and a surplus address byte between data bytes. It then confirms and watches the pointer fall back. Erase is driven over a sweep of rows whose page bits are nonzero. Each confirm is also broken in turn by a missing row byte, a reset, or a confirm with no open erase.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  localparam int BUS_W    = 8;
  localparam int HALF_SZ  = 2 ** BUS_W;
  localparam int SPARE_SZ = 16;
  localparam int SPARE_W  = $clog2(SPARE_SZ);
  localparam int COL_W    = $clog2(2 * HALF_SZ + SPARE_SZ);

  typedef enum logic [1:0] {AREA_LO = 2'd0, AREA_HI = 2'd1, AREA_SP = 2'd2} area_e;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_RD_LO, CMD_RD_HI, CMD_RD_SP, CMD_LOAD, CMD_PROG,
    CMD_ER_OPEN, CMD_ER_GO, CMD_ID, CMD_STATUS, CMD_RESET
  } cmd_e;

  typedef enum logic [2:0] {SQ_IDLE, SQ_RD_ADDR, SQ_PG_ADDR, SQ_PG_DATA, SQ_ER_ADDR} seq_e;

  // Internal column from area and column byte.
  function automatic logic [COL_W-1:0] col_of(area_e a, logic [BUS_W-1:0] b);
    case (a)
      AREA_HI: return COL_W'(HALF_SZ) + COL_W'(b);
      AREA_SP: return COL_W'(2 * HALF_SZ) + COL_W'(b[SPARE_W-1:0]);
      default: return COL_W'(b);
    endcase
  endfunction

  // Next column, wrapping inside the area.
  function automatic logic [COL_W-1:0] next_col(area_e a, logic [COL_W-1:0] c);
    logic [COL_W-1:0] base, n;
    base = col_of(a, '0);
    n    = c + 1'b1;
    if (a == AREA_SP) return (n == base + COL_W'(SPARE_SZ)) ? base : n;
    return (n == base + COL_W'(HALF_SZ)) ? base : n;
  endfunction
endpackage

// File: rtl/nand_bus_sample.sv
module nand_bus_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic cle,
  input  logic ale,
  output logic cyc_cmd,
  output logic cyc_addr,
  output logic cyc_data
);
  logic we_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign rise     = !we_q && we_n && !ce_n;
  assign cyc_cmd  = rise && cle && !ale;
  assign cyc_addr = rise && ale && !cle;
  assign cyc_data = rise && !cle && !ale;
endmodule

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode import nand_fe_pkg::*; (
  input  logic [BUS_W-1:0] io,
  input  logic             se_n,
  output cmd_e             cmd
);
  always_comb begin
    case (io)
      8'h00:   cmd = CMD_RD_LO;
      8'h01:   cmd = CMD_RD_HI;
      8'h50:   cmd = se_n ? CMD_NONE : CMD_RD_SP;
      8'h80:   cmd = CMD_LOAD;
      8'h10:   cmd = CMD_PROG;
      8'h60:   cmd = CMD_ER_OPEN;
      8'hD0:   cmd = CMD_ER_GO;
      8'h90:   cmd = CMD_ID;
      8'h70:   cmd = CMD_STATUS;
      8'hFF:   cmd = CMD_RESET;
      default: cmd = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq import nand_fe_pkg::*; #(
  parameter int ROW_W  = 15,
  parameter int PAGE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_v,
  input  logic                    addr_v,
  input  logic                    data_v,
  input  cmd_e                    cmd,
  input  logic [BUS_W-1:0]        io,
  output logic                    rd_go,
  output logic                    prog_go,
  output logic                    erase_go,
  output logic                    id_go,
  output logic                    status_go,
  output logic                    reset_go,
  output logic [COL_W-1:0]        op_col,
  output logic [ROW_W-1:0]        op_row,
  output logic [ROW_W-PAGE_W-1:0] erase_blk,
  output logic                    pg_we,
  output logic [COL_W-1:0]        pg_col,
  output logic [BUS_W-1:0]        pg_data,
  output logic [1:0]              area_o
);
  localparam int HI_W = ROW_W - BUS_W;

  seq_e             st;
  area_e            area;
  logic [1:0]       cnt;
  logic [COL_W-1:0] col, wcol;
  logic [ROW_W-1:0] row;
  logic [ROW_W-1:0] row_full;

  assign row_full = {io[HI_W-1:0], row[BUS_W-1:0]};
  assign area_o   = area;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; area <= AREA_LO; cnt <= '0;
      col <= '0; wcol <= '0; row <= '0;
      rd_go <= 1'b0; prog_go <= 1'b0; erase_go <= 1'b0;
      id_go <= 1'b0; status_go <= 1'b0; reset_go <= 1'b0; pg_we <= 1'b0;
      op_col <= '0; op_row <= '0; erase_blk <= '0; pg_col <= '0; pg_data <= '0;
    end else begin
      rd_go <= 1'b0; prog_go <= 1'b0; erase_go <= 1'b0;
      id_go <= 1'b0; status_go <= 1'b0; reset_go <= 1'b0; pg_we <= 1'b0;
      if (cmd_v) begin
        case (cmd)
          CMD_RD_LO:   begin area <= AREA_LO; st <= SQ_RD_ADDR; cnt <= '0; end
          CMD_RD_HI:   begin area <= AREA_HI; st <= SQ_RD_ADDR; cnt <= '0; end
          CMD_RD_SP:   begin area <= AREA_SP; st <= SQ_RD_ADDR; cnt <= '0; end
          CMD_LOAD:    begin st <= SQ_PG_ADDR; cnt <= '0; end
          CMD_ER_OPEN: begin st <= SQ_ER_ADDR; cnt <= '0; end
          CMD_PROG: if (st == SQ_PG_DATA) begin
            prog_go <= 1'b1; op_col <= col; op_row <= row; st <= SQ_IDLE;
            if (area == AREA_HI) area <= AREA_LO;
          end
          CMD_ER_GO: if (st == SQ_ER_ADDR && cnt == 2'd2) begin
            erase_go <= 1'b1; erase_blk <= row[ROW_W-1:PAGE_W]; st <= SQ_IDLE;
          end
          CMD_ID:     begin id_go <= 1'b1; st <= SQ_IDLE; end
          CMD_STATUS: status_go <= 1'b1;
          CMD_RESET:  begin reset_go <= 1'b1; st <= SQ_IDLE; area <= AREA_LO; end
          default: ;
        endcase
      end else if (addr_v) begin
        if (st == SQ_RD_ADDR || st == SQ_PG_ADDR) begin
          if (cnt == 2'd0) begin
            col <= col_of(area, io); cnt <= 2'd1;
          end else if (cnt == 2'd1) begin
            row[BUS_W-1:0] <= io; cnt <= 2'd2;
          end else begin
            row <= row_full;
            if (st == SQ_RD_ADDR) begin
              rd_go <= 1'b1; op_col <= col; op_row <= row_full; st <= SQ_IDLE;
              if (area == AREA_HI) area <= AREA_LO;
            end else begin
              st <= SQ_PG_DATA; wcol <= col;
            end
          end
        end else if (st == SQ_ER_ADDR) begin
          if (cnt == 2'd0) begin
            row[BUS_W-1:0] <= io; cnt <= 2'd1;
          end else if (cnt == 2'd1) begin
            row <= row_full; cnt <= 2'd2;
          end
        end
      end else if (data_v && st == SQ_PG_DATA) begin
        pg_we <= 1'b1; pg_col <= wcol; pg_data <= io;
        wcol <= next_col(area, wcol);
      end
    end
  end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front import nand_fe_pkg::*; #(
  parameter int ROW_W  = 15,
  parameter int PAGE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    cle,
  input  logic                    ale,
  input  logic                    se_n,
  input  logic [BUS_W-1:0]        io,
  output logic                    rd_go,
  output logic                    prog_go,
  output logic                    erase_go,
  output logic                    id_go,
  output logic                    status_go,
  output logic                    reset_go,
  output logic [COL_W-1:0]        op_col,
  output logic [ROW_W-1:0]        op_row,
  output logic [ROW_W-PAGE_W-1:0] erase_blk,
  output logic                    pg_we,
  output logic [COL_W-1:0]        pg_col,
  output logic [BUS_W-1:0]        pg_data,
  output logic [1:0]              area
);
  logic cyc_cmd, cyc_addr, cyc_data;
  cmd_e cmd;

  nand_bus_sample u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .cyc_cmd(cyc_cmd), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
  );

  nand_cmd_decode u_dec (.io(io), .se_n(se_n), .cmd(cmd));

  nand_op_seq #(.ROW_W(ROW_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_v(cyc_cmd), .addr_v(cyc_addr), .data_v(cyc_data),
    .cmd(cmd), .io(io), .rd_go(rd_go), .prog_go(prog_go), .erase_go(erase_go),
    .id_go(id_go), .status_go(status_go), .reset_go(reset_go), .op_col(op_col),
    .op_row(op_row), .erase_blk(erase_blk), .pg_we(pg_we), .pg_col(pg_col),
    .pg_data(pg_data), .area_o(area)
  );
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       se_n,
  input logic [7:0] io,
  input logic       cyc_cmd,
  input logic       cyc_addr,
  input logic       cyc_data,
  input logic       rd_go,
  input logic       prog_go,
  input logic       erase_go,
  input logic       id_go,
  input logic       status_go,
  input logic       reset_go,
  input logic       pg_we,
  input logic [9:0] pg_col,
  input logic [1:0] area
);
  AST_CMD_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go || id_go || status_go || reset_go) |-> $past(cyc_cmd)); // R1
  AST_READ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> $past(cyc_addr)); // R2
  AST_WRITE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> $past(cyc_data)); // R9
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, prog_go, erase_go, id_go, status_go, reset_go, pg_we})); // R11
  AST_HI_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || prog_go) |-> area != 2'd1); // R4
  AST_SPARE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (area == 2'd2 && $past(area) != 2'd2) |-> !$past(se_n)); // R5
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> pg_col < 10'd528); // R6
  AST_PROG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> $past(io) == 8'h10); // R7
  AST_ERASE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> $past(io) == 8'hD0); // R8
  AST_RESET_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    reset_go |-> area == 2'd0); // R10
endmodule

bind nand_cmd_front nand_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .se_n(se_n), .io(io), .cyc_cmd(cyc_cmd),
  .cyc_addr(cyc_addr), .cyc_data(cyc_data), .rd_go(rd_go), .prog_go(prog_go),
  .erase_go(erase_go), .id_go(id_go), .status_go(status_go), .reset_go(reset_go),
  .pg_we(pg_we), .pg_col(pg_col), .area(area)
);

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0, se_n = 1'b0;
  logic [7:0] io = 8'h00;
  logic rd_go, prog_go, erase_go, id_go, status_go, reset_go, pg_we;
  logic [9:0] op_col, erase_blk, pg_col;
  logic [14:0] op_row;
  logic [7:0] pg_data;
  logic [1:0] area;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  nand_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale), .se_n(se_n),
    .io(io), .rd_go(rd_go), .prog_go(prog_go), .erase_go(erase_go), .id_go(id_go),
    .status_go(status_go), .reset_go(reset_go), .op_col(op_col), .op_row(op_row),
    .erase_blk(erase_blk), .pg_we(pg_we), .pg_col(pg_col), .pg_data(pg_data), .area(area)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int strobes();
    return {25'd0, rd_go, prog_go, erase_go, id_go, status_go, reset_go, pg_we};
  endfunction

  function automatic int exp_col(int a, int b);
    if (a == 1) return 256 + b;
    if (a == 2) return 512 + (b % 16);
    return b;
  endfunction

  // One bus cycle; returns at the negedge where its strobes are visible.
  task automatic bus(input bit c, input bit a, input logic [7:0] d, input bit ce_hi = 1'b0);
    ce_n = ce_hi; cle = c; ale = a; io = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);  bus(1'b1, 1'b0, d); endtask
  task automatic addr(input logic [7:0] d); bus(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  bus(1'b0, 1'b0, d); endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobes() == 0 && area == 2'd0, "R10 reset state", strobes() + 100 * area, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4: read sweep over all areas
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 256; b += 15) begin
        int row;
        row = (b * 123 + a * 4099) % 32768;
        cmd(a == 0 ? 8'h00 : (a == 1 ? 8'h01 : 8'h50));
        chk(area == 2'(a), "R2 area select", area, a);
        addr(8'(b)); addr(8'(row & 255)); addr(8'(row >> 8));
        chk(rd_go == 1'b1, "R2 rd_go", rd_go, 1);
        chk(op_col == 10'(exp_col(a, b)), "R3 column", op_col, exp_col(a, b));
        chk(op_row == 15'(row), "R2 row", op_row, row);
        chk(area == 2'(a == 1 ? 0 : a), "R4 pointer after read", area, a == 1 ? 0 : a);
      end
    end
    addr(8'h12);
    chk(strobes() == 0, "R9 surplus address after read", strobes(), 0);
    dat(8'h34);
    chk(strobes() == 0, "R9 data outside program", strobes(), 0);

    // R5: spare select blocked
    cmd(8'h01); se_n = 1'b1; cmd(8'h50);
    chk(area == 2'd1, "R5 50h ignored", area, 1);
    se_n = 1'b0;
    // R1: cycle with chip select high ignored
    bus(1'b1, 1'b0, 8'hFF, 1'b1);
    chk(reset_go == 1'b0 && area == 2'd1, "R1 ce_n high ignored", area, 1);
    ce_n = 1'b0;
    // R1: both latches high ignored
    bus(1'b1, 1'b1, 8'hFF);
    chk(reset_go == 1'b0 && area == 2'd1, "R1 both latches ignored", area, 1);
    cmd(8'hFF);
    chk(reset_go == 1'b1 && area == 2'd0, "R10 reset", area, 0);

    // R6: program in upper half across the wrap
    cmd(8'h01); cmd(8'h80);
    addr(8'd250); addr(8'h34); addr(8'h12);
    for (int i = 0; i < 10; i++) begin
      int ec;
      ec = 256 + ((250 + i) % 256);
      if (i == 4) begin
        addr(8'h77);
        chk(strobes() == 0, "R9 surplus address in data phase", strobes(), 0);
        cmd(8'h70);
        chk(status_go == 1'b1, "R11 status mid program", status_go, 1);
      end
      dat(8'(i * 29 + 3));
      chk(pg_we == 1'b1 && pg_col == 10'(ec), "R6 data column", pg_col, ec);
      chk(pg_data == 8'(i * 29 + 3), "R6 data byte", pg_data, i * 29 + 3);
    end
    cmd(8'h10);
    chk(prog_go == 1'b1 && op_col == 10'd506, "R6 program start col", op_col, 506);
    chk(op_row == 15'h1234, "R6 program row", op_row, 15'h1234);
    chk(area == 2'd0, "R4 pointer after program", area, 0);

    // R6: spare program wraps 527 -> 512
    cmd(8'h50); cmd(8'h80);
    addr(8'hFE); addr(8'h01); addr(8'h00);
    for (int i = 0; i < 4; i++) begin
      int ec;
      ec = 512 + ((14 + i) % 16);
      dat(8'(i));
      chk(pg_we == 1'b1 && pg_col == 10'(ec), "R6 spare wrap", pg_col, ec);
    end
    cmd(8'h10);
    chk(prog_go == 1'b1 && op_col == 10'd526, "R6 spare start", op_col, 526);
    chk(area == 2'd2, "R4 spare kept", area, 2);
    cmd(8'h00);

    // R7: lone confirm
    cmd(8'h10);
    chk(strobes() == 0, "R7 lone 10h", strobes(), 0);

    // R8: erase sweep
    for (int k = 0; k < 24; k++) begin
      int row;
      row = (k * 1337 * 32 + k) % 32768;
      cmd(8'h60); addr(8'(row & 255)); addr(8'(row >> 8));
      if (k % 4 == 0) begin
        addr(8'hAA);
        chk(strobes() == 0, "R9 surplus erase address", strobes(), 0);
      end
      cmd(8'hD0);
      chk(erase_go == 1'b1 && erase_blk == 10'(row >> 5), "R8 erase block", erase_blk, row >> 5);
    end
    cmd(8'hD0);
    chk(strobes() == 0, "R8 lone D0h", strobes(), 0);
    cmd(8'h60); addr(8'h05); cmd(8'hD0);
    chk(strobes() == 0, "R8 D0h after one row", strobes(), 0);
    cmd(8'h60); addr(8'h05); addr(8'h01); cmd(8'hFF);
    chk(reset_go == 1'b1, "R10 reset mid erase", reset_go, 1);
    cmd(8'hD0);
    chk(strobes() == 0, "R10 erase abandoned", strobes(), 0);

    // R11: id, unknown code
    cmd(8'h90);
    chk(id_go == 1'b1 && strobes() == 8, "R11 id strobe", strobes(), 8);
    cmd(8'h01); cmd(8'h33);
    chk(strobes() == 0 && area == 2'd1, "R11 unknown code", area, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule